// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block is the execute stage for register-to-register arithmetic and logic in a 32-bit load/store processor. Each cycle it receives an instruction word, two operand values and the current N, Z, C, V flags. The second operand arrives already shifted or rotated, with the shifter's carry-out on its own pin. From the top four bits of the instruction the unit decides whether the instruction runs. It then performs one of sixteen operations and registers a result, a write strobe, the next flag value and a flag strobe.

Four of the sixteen operations exist only to set flags: two tests and two compares. They never request a register write. The other twelve touch the flags only when the instruction's set-flags bit is 1. A wide add can therefore be chained: a flag-setting add on the low words, then an add-with-carry on the high words. All outputs are registered and appear on the clock edge after the inputs.

Top module: `dp_cond_alu`

## Requirements
- R1: While `rst_n` is low, `result`, `result_we`, `flags_out` and `flags_we` are all 0.
- R2: Outputs are registered. Inputs present before a rising edge appear on the outputs only after that edge.
- R3: Condition field `instr[31:28]` is checked against `flags_in` = {N,Z,C,V} (bit 3 = N). The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
- R4: Condition 14 always executes. Condition 15 never executes.
- R5: Opcode `instr[24:21]` selects the logical operations: 0 a&b, 1 a^b, 12 a|b, 13 b, 14 a&~b, 15 ~b. The result is written (`result_we`=1) when the instruction executes.
- R6: The opcode selects the arithmetic operations: 2 a-b, 3 b-a, 4 a+b, 5 a+b+C, 6 a-b-!C, 7 b-a-!C. Each is computed modulo 2^32 and written when the instruction executes.
- R7: For arithmetic operations with flags updated, C is the adder carry-out, which is NOT borrow for subtraction. V is signed overflow. N is bit 31 and Z means a zero result.
- R8: For logical operations with flags updated, C takes `shift_carry`, V keeps its input value, N is bit 31 and Z means a zero result.
- R9: With `instr[20]`=0, a non-compare instruction leaves `flags_we`=0 and `flags_out` equal to `flags_in`.
- R10: Opcodes 8 (test a&b), 9 (test a^b), 10 (compare a-b) and 11 (compare a+b) update flags whenever they execute, whatever `instr[20]` is. They never assert `result_we`.
- R11: When the condition fails, `result_we`=0, `flags_we`=0 and `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word: condition, opcode, set-flags bit |
| op_a | input | 32 | First register operand |
| op_b | input | 32 | Resolved second operand |
| shift_carry | input | 1 | Carry-out of the operand-2 shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Registered operation result |
| result_we | output | 1 | Destination register write strobe |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| flags_we | output | 1 | Flags changed by this instruction |

## Verification
The hardest cases to reach are those where several rules meet at once. Examples are a compare with the set-flags bit clear under a passing condition, or a subtract-with-carry whose incoming C flips the borrow exactly at the signed overflow boundary. Random stimulus seldom lines all of these up together. The bench therefore sweeps every condition code against every flag combination, for every opcode and both set-flags values. It repeats that sweep over operand pairs chosen to sit on the zero, sign and carry boundaries, so every such pairing is driven deliberately.

// File: rtl/dp_cond_alu.sv
module dp_cond_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  instr,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_carry,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [3:0]   flags_out,
  output logic         flags_we
);
  localparam logic [3:0] OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
                         OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
                         OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
                         OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF;

  logic n_f, z_f, c_f, v_f;
  assign {n_f, z_f, c_f, v_f} = flags_in;

  wire [3:0] cond  = instr[31:28];
  wire [3:0] opc   = instr[24:21];
  wire       s_bit = instr[20];
  wire       cmp_only = (opc[3:2] == 2'b10);

  logic pass;
  always_comb begin
    case (cond)
      4'h0: pass = z_f;
      4'h1: pass = !z_f;
      4'h2: pass = c_f;
      4'h3: pass = !c_f;
      4'h4: pass = n_f;
      4'h5: pass = !n_f;
      4'h6: pass = v_f;
      4'h7: pass = !v_f;
      4'h8: pass = c_f && !z_f;
      4'h9: pass = !c_f || z_f;
      4'hA: pass = (n_f == v_f);
      4'hB: pass = (n_f != v_f);
      4'hC: pass = !z_f && (n_f == v_f);
      4'hD: pass = z_f || (n_f != v_f);
      4'hE: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  logic [W-1:0] ax, ay;
  logic         acin;
  logic         arith;
  always_comb begin
    arith = 1'b1;
    ax    = op_a;
    ay    = op_b;
    acin  = 1'b0;
    case (opc)
      OP_SUB, OP_CMP: begin ay = ~op_b; acin = 1'b1; end
      OP_RSB:         begin ax = op_b; ay = ~op_a; acin = 1'b1; end
      OP_ADD, OP_CMN: acin = 1'b0;
      OP_ADC:         acin = c_f;
      OP_SBC:         begin ay = ~op_b; acin = c_f; end
      OP_RSC:         begin ax = op_b; ay = ~op_a; acin = c_f; end
      default:        arith = 1'b0;
    endcase
  end

  wire [W:0]   sum   = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, acin};
  wire         a_ovf = (ax[W-1] == ay[W-1]) && (sum[W-1] != ax[W-1]);

  logic [W-1:0] lres;
  always_comb begin
    case (opc)
      OP_AND, OP_TST: lres = op_a & op_b;
      OP_EOR, OP_TEQ: lres = op_a ^ op_b;
      OP_ORR:         lres = op_a | op_b;
      OP_MOV:         lres = op_b;
      OP_BIC:         lres = op_a & ~op_b;
      OP_MVN:         lres = ~op_b;
      default:        lres = '0;
    endcase
  end

  wire [W-1:0] res_d  = arith ? sum[W-1:0] : lres;
  wire         upd    = pass && (s_bit || cmp_only);
  wire         c_new  = arith ? sum[W] : shift_carry;
  wire         v_new  = arith ? a_ovf : v_f;
  wire [3:0]   flg_d  = upd ? {res_d[W-1], (res_d == '0), c_new, v_new} : flags_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= 4'h0;
      flags_we  <= 1'b0;
    end else begin
      result    <= res_d;
      result_we <= pass && !cmp_only;
      flags_out <= flg_d;
      flags_we  <= upd;
    end
  end
endmodule

// File: rtl/dp_cond_alu_chk.sv
module dp_cond_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [31:0]  instr,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         shift_carry,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [3:0]   flags_out,
  input logic         flags_we
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!result_we && !flags_we)); // R1
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[24:23] == 2'b10) |=> !result_we); // R10
  AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:28] == 4'hE && instr[24:23] != 2'b10) |=> result_we); // R4
  AST_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[31:28] == 4'hF) |=> (!result_we && !flags_we)); // R11
  AST_NO_S_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr[20] && instr[24:23] != 2'b10) |=> !flags_we); // R9
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n || !live)
    !flags_we |-> flags_out == $past(flags_in)); // R11
  AST_ZN_MATCH: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (flags_we && result_we) |-> (flags_out[3] == result[W-1] && flags_out[2] == (result == '0))); // R7
  AST_LOGIC_V_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[20] && instr[31:28] == 4'hE && (instr[24:21] == 4'h0 || instr[24:21] == 4'hD))
      |=> (flags_out[0] == $past(flags_in[0]) && flags_out[1] == $past(shift_carry))); // R8
endmodule

bind dp_cond_alu dp_cond_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_dp_cond_alu.sv
module tb_dp_cond_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = '0, op_a = '0, op_b = '0;
  logic        shift_carry = 1'b0;
  logic [3:0]  flags_in = '0;
  logic [31:0] result;
  logic        result_we, flags_we;
  logic [3:0]  flags_out;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  dp_cond_alu dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h (instr %h a %h b %h f %h)", tag, got, exp, instr, op_a, op_b, flags_in);
    end
  endtask

  function automatic bit cond_ok(logic [3:0] c, logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;  1: return !z;  2: return cy; 3: return !cy;
      4: return n;  5: return !n;  6: return v;  7: return !v;
      8: return cy & !z;  9: return !cy | z;
      10: return n == v;  11: return n != v;
      12: return !z & (n == v);  13: return z | (n != v);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic model(input logic [31:0] ins, a, b, input logic sc, input logic [3:0] f,
                       output logic [31:0] r, output logic we, output logic [3:0] fo,
                       output logic fwe, output bit ar);
    logic [3:0] op = ins[24:21];
    bit cmpop = (op >= 8 && op <= 11);
    bit ex = cond_ok(ins[31:28], f);
    longint ua = a, ub = b, cin = f[1];
    longint sa = $signed(a), sb = $signed(b);
    longint us, ss;
    ar = 1;
    case (op)
      2, 10: begin us = ua - ub;             ss = sa - sb;             end
      3:     begin us = ub - ua;             ss = sb - sa;             end
      4, 11: begin us = ua + ub;             ss = sa + sb;             end
      5:     begin us = ua + ub + cin;       ss = sa + sb + cin;       end
      6:     begin us = ua - ub - (1 - cin); ss = sa - sb - (1 - cin); end
      7:     begin us = ub - ua - (1 - cin); ss = sb - sa - (1 - cin); end
      default: begin ar = 0; us = 0; ss = 0; end
    endcase
    if (ar) r = us[31:0];
    else case (op)
      0, 8: r = a & b;  1, 9: r = a ^ b;  12: r = a | b;
      13: r = b;        14: r = a & ~b;   default: r = ~b;
    endcase
    we  = ex && !cmpop;
    fwe = ex && (ins[20] || cmpop);
    fo  = f;
    if (fwe) begin
      fo[3] = r[31];
      fo[2] = (r == 0);
      if (ar) begin
        fo[1] = (op == 4 || op == 5 || op == 11) ? (us > 64'sd4294967295) : (us >= 0);
        fo[0] = (ss != longint'($signed(r)));
      end else fo[1] = sc;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] pa [6] = '{32'h0, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h5, 32'h9abc0123};
    logic [31:0] pb [6] = '{32'h0, 32'h1, 32'h80000000, 32'h1, 32'h9, 32'h9abc0123};
    logic [31:0] er; logic ew, efw, ar; logic [3:0] ef;
    repeat (3) @(negedge clk);
    chk("R1 result", result, 0);
    chk("R1 result_we", {31'b0, result_we}, 0);
    chk("R1 flags_out", {28'b0, flags_out}, 0);
    chk("R1 flags_we", {31'b0, flags_we}, 0);
    rst_n = 1'b1;
    instr = {4'hE, 3'b000, 4'hD, 1'b0, 20'h0}; op_b = 32'h1234;
    #1 chk("R2 before edge", result, 0);
    @(posedge clk); @(negedge clk);
    chk("R2 after edge", result, 32'h1234);
    instr = {4'hF, 3'b000, 4'h4, 1'b1, 20'h0}; op_a = 1; op_b = 2; flags_in = 4'h5;
    @(posedge clk); @(negedge clk);
    chk("R4 never we", {31'b0, result_we}, 0);
    chk("R4 never flags", {28'b0, flags_out}, 32'h5);
    instr = {4'hE, 3'b000, 4'h4, 1'b1, 20'h0}; flags_in = 4'h0;
    @(posedge clk); @(negedge clk);
    chk("R4 always we", {31'b0, result_we}, 1);
    chk("R6 add", result, 3);
    // 64-bit chain: flag-setting add then add-with-carry
    instr = {4'hE, 3'b000, 4'h4, 1'b1, 20'h0}; op_a = 32'hffffffff; op_b = 32'h2;
    @(posedge clk); @(negedge clk);
    chk("R7 carry low", {31'b0, flags_out[1]}, 1);
    instr = {4'hE, 3'b000, 4'h5, 1'b0, 20'h0}; op_a = 32'h10; op_b = 32'h20; flags_in = flags_out;
    @(posedge clk); @(negedge clk);
    chk("R6 adc high", result, 32'h31);
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 16; c++)
        for (int f = 0; f < 16; f++)
          for (int o = 0; o < 16; o++)
            for (int s = 0; s < 2; s++) begin
              instr = {c[3:0], 3'b001, o[3:0], s[0], 20'hA5C3E};
              op_a = pa[p]; op_b = pb[p]; flags_in = f[3:0];
              shift_carry = c[0] ^ o[0] ^ p[0];
              model(instr, op_a, op_b, shift_carry, flags_in, er, ew, ef, efw, ar);
              @(posedge clk); @(negedge clk);
              if (!cond_ok(c[3:0], f[3:0])) begin
                chk("R11 we", {31'b0, result_we}, 0);
                chk("R11 flags", {27'b0, flags_we, flags_out}, {27'b0, 1'b0, flags_in});
              end else if (o >= 8 && o <= 11) begin
                chk("R10 we", {31'b0, result_we}, 0);
                chk("R10 flags", {27'b0, flags_we, flags_out}, {27'b0, 1'b1, ef});
              end else begin
                chk("R3 we", {31'b0, result_we}, {31'b0, ew});
                chk(ar ? "R6 result" : "R5 result", result, er);
                if (s == 0) chk("R9 flags", {27'b0, flags_we, flags_out}, {27'b0, 1'b0, flags_in});
                else chk(ar ? "R7 flags" : "R8 flags", {27'b0, flags_we, flags_out}, {27'b0, 1'b1, ef});
              end
            end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule